// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture Channels

This block is a free-running up-counter for a peripheral subsystem. In timer mode a prescaler divides the peripheral clock, and the counter steps once per prescaler wrap. In counter mode the counter instead steps once for each selected edge on one of the capture pins, and the prescaler is bypassed.

Four match channels compare the counter against their own compare values. A match is evaluated only on a step, so each match is seen for exactly one counter value. On a match, a channel can raise a sticky interrupt flag, send the counter back to zero, stop the counter, and drive its output pin low, high, toggled or unchanged.

Capture channels pass their pins through a synchroniser and watch for the edges selected for that channel. On a selected edge they copy the counter into a capture register, and they can raise a flag of their own. Software configures and observes everything through a flat word-addressed register port with single-cycle writes and combinational reads.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset every register reads zero, all match pins are low and `irq_o` is low.
- R2: Control bit 0 enables counting and control bit 1 holds the counter and prescaler at zero. The prescale limit is at word 1. In timer mode the prescaler counts 0..limit, and the counter advances by one on each wrap, so it steps once every limit+1 enabled cycles. The counter reads at word 2 and the prescaler at word 3.
- R3: A match channel hits when the counter equals its compare value (words 8..11) on a step. Its reset action (bit 3i+1 of word 4) loads zero instead of value+1, so the count period is value+1 steps.
- R4: The stop action (bit 3i+2 of word 4) clears control bit 0 on the hit and freezes the counter at the matched value. With reset also set, the counter becomes zero and the enable clears on the same edge.
- R5: Each match pin reacts to a hit according to its 2-bit field at word 5, bits 2i+1:2i: 00 leaves it unchanged, 01 drives it low, 10 drives it high and 11 toggles it.
- R6: A hit with the interrupt action (bit 3i of word 4) sets flag bit i at word 7. Flags stay set until software writes 1 to them, and `irq_o` is high while any flag is set.
- R7: Each capture channel has a 3-bit field at word 6, bits 3i+2:3i, holding rise, fall and interrupt enables from low to high. A selected edge copies the counter into the capture register (words 12..) on the third clock edge after the pin changes. An edge that is not selected leaves the register unchanged.
- R8: A selected capture edge with its interrupt enable set sets flag bit NUM_MATCH+i at word 7.
- R9: Control bit 2 selects counter mode. Control bits 5:4 pick the source capture pin, and bits 7:6 pick the rising and/or falling edges. Each selected edge of that pin advances the enabled counter by one whatever the prescale limit, and edges on other pins have no effect.
- R10: The configuration registers (control, prescale limit, match controls, pin controls, capture controls, compare values) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 5 | Register word address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for `bus_addr_i` |
| cap_pin_i | input | NUM_CAP | Asynchronous capture / count pins |
| match_pin_o | output | NUM_MATCH | Match-driven output pins |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
On every cycle, assertions check the following:
- the counter steps by exactly one on a tick and holds otherwise;
- a reset hit yields zero, and a stop hit clears the enable and freezes the count;
- the prescaler restarts after each wrap;
- pins and capture registers move only on their own events;
- flags never drop without a clearing write.

The scenarios are needed for the things assertions cannot show:
- the absolute periods that result from a prescale limit and a compare value;
- the pin values after sequences of actions;
- which capture edges are ignored;
- the exact flag bit positions;
- that counter mode counts only the chosen pin's chosen edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int unsigned ADDR_W = 5;

   // register word addresses
   localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
   localparam logic [ADDR_W-1:0] A_PRE    = 5'd1;
   localparam logic [ADDR_W-1:0] A_CNT    = 5'd2;
   localparam logic [ADDR_W-1:0] A_PCNT   = 5'd3;
   localparam logic [ADDR_W-1:0] A_MCTL   = 5'd4;
   localparam logic [ADDR_W-1:0] A_PINCTL = 5'd5;
   localparam logic [ADDR_W-1:0] A_CCTL   = 5'd6;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 5'd7;
   localparam logic [ADDR_W-1:0] A_MR0    = 5'd8;
   localparam logic [ADDR_W-1:0] A_CAP0   = 5'd12;

   // control register bit positions
   localparam int CB_EN      = 0;
   localparam int CB_HOLD    = 1;
   localparam int CB_CMODE   = 2;
   localparam int CB_SRC_LO  = 4;
   localparam int CB_EDGE_LO = 6;

   typedef enum logic [1:0] {
      PIN_KEEP   = 2'b00,
      PIN_LOW    = 2'b01,
      PIN_HIGH   = 2'b10,
      PIN_TOGGLE = 2'b11
   } pin_act_e;

   typedef struct packed {
      logic stop;
      logic rst;
      logic irq;
   } match_cfg_t;

   typedef struct packed {
      logic irq;
      logic fall;
      logic rise;
   } cap_cfg_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         run_i,
   input  logic         clr_i,
   input  logic [W-1:0] limit_i,
   output logic [W-1:0] pc_o,
   output logic         wrap_o
);

   logic [W-1:0] pc_q;

   // >= keeps the divider bounded when the limit is lowered mid-count
   assign wrap_o = run_i && (pc_q >= limit_i);
   assign pc_o   = pc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pc_q <= '0;
      else if (clr_i)   pc_q <= '0;
      else if (wrap_o)  pc_q <= '0;
      else if (run_i)   pc_q <= pc_q + 1'b1;
   end

   p_wrap_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (pc_q == '0));

   p_idle_freeze_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !clr_i) |=> $stable(pc_q));

endmodule

// File: rtl/tmr_match_ch.sv
module tmr_match_ch
   import tmr_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic [W-1:0] count_i,
   input  logic [W-1:0] match_i,
   input  match_cfg_t   cfg_i,
   input  pin_act_e     act_i,
   output logic         rst_req_o,
   output logic         stop_req_o,
   output logic         irq_set_o,
   output logic         pin_o
);

   logic hit;
   logic pin_q;

   assign hit        = tick_i && (count_i == match_i);
   assign rst_req_o  = hit && cfg_i.rst;
   assign stop_req_o = hit && cfg_i.stop;
   assign irq_set_o  = hit && cfg_i.irq;
   assign pin_o      = pin_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pin_q <= 1'b0;
      end else if (hit) begin
         unique case (act_i)
            PIN_KEEP:   pin_q <= pin_q;
            PIN_LOW:    pin_q <= 1'b0;
            PIN_HIGH:   pin_q <= 1'b1;
            PIN_TOGGLE: pin_q <= ~pin_q;
         endcase
      end
   end

   p_pin_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit |=> $stable(pin_q));

   p_pin_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && act_i == PIN_TOGGLE) |=> (pin_q != $past(pin_q)));

endmodule

// File: rtl/tmr_capture_ch.sv
module tmr_capture_ch
   import tmr_pkg::*;
#(
   parameter int unsigned W           = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         pin_i,
   input  cap_cfg_t     cfg_i,
   input  logic [W-1:0] count_i,
   output logic [W-1:0] cap_o,
   output logic         irq_set_o,
   output logic         rise_o,
   output logic         fall_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   evt;
   logic [W-1:0]           cap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise_o    = sync_q[SYNC_STAGES-1] && !prev_q;
   assign fall_o    = !sync_q[SYNC_STAGES-1] && prev_q;
   assign evt       = (rise_o && cfg_i.rise) || (fall_o && cfg_i.fall);
   assign irq_set_o = evt && cfg_i.irq;
   assign cap_o     = cap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cap_q <= '0;
      else if (evt)  cap_q <= count_i;
   end

   p_cap_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !evt |=> $stable(cap_q));

   p_cap_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt |=> (cap_q == $past(count_i)));

endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned NUM_MATCH   = 4,
   parameter int unsigned NUM_CAP     = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   input  logic                 bus_wr_i,
   input  logic [CNT_W-1:0]     bus_wdata_i,
   output logic [CNT_W-1:0]     bus_rdata_o,
   input  logic [NUM_CAP-1:0]   cap_pin_i,
   output logic [NUM_MATCH-1:0] match_pin_o,
   output logic                 irq_o
);

   localparam int unsigned NF    = NUM_MATCH + NUM_CAP;
   localparam int unsigned MCT_W = 3 * NUM_MATCH;
   localparam int unsigned PIN_W = 2 * NUM_MATCH;
   localparam int unsigned CCT_W = 3 * NUM_CAP;

   // elaboration-time parameter checks
   if (NUM_MATCH < 1 || NUM_MATCH > 4) begin : g_bad_match
      $error("NUM_MATCH must be 1..4");
   end
   if (NUM_CAP < 1 || NUM_CAP > 4) begin : g_bad_cap
      $error("NUM_CAP must be 1..4");
   end
   if (CNT_W < 12) begin : g_bad_width
      $error("CNT_W must be at least 12");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // ---------------- registers ----------------
   logic [7:0]        ctrl_q;
   logic [CNT_W-1:0]  pre_q;
   logic [CNT_W-1:0]  tc_q;
   logic [MCT_W-1:0]  mctl_q;
   logic [PIN_W-1:0]  pinctl_q;
   logic [CCT_W-1:0]  cctl_q;
   logic [CNT_W-1:0]  mr_q [NUM_MATCH];
   logic [NF-1:0]     flags_q;

   logic wr_ctrl, wr_flags;
   assign wr_ctrl  = bus_wr_i && (bus_addr_i == A_CTRL);
   assign wr_flags = bus_wr_i && (bus_addr_i == A_FLAGS);

   logic en, hold, cmode;
   assign en    = ctrl_q[CB_EN];
   assign hold  = ctrl_q[CB_HOLD];
   assign cmode = ctrl_q[CB_CMODE];

   // ---------------- prescaler ----------------
   logic [CNT_W-1:0] pc_w;
   logic             psc_wrap;

   tmr_prescaler #(.W(CNT_W)) u_psc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (en && !hold && !cmode),
      .clr_i   (hold),
      .limit_i (pre_q),
      .pc_o    (pc_w),
      .wrap_o  (psc_wrap)
   );

   // ---------------- capture channels ----------------
   logic [CNT_W-1:0]   cap_w [NUM_CAP];
   logic [NUM_CAP-1:0] cap_set_w, rise_w, fall_w;

   for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
      tmr_capture_ch #(.W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .pin_i     (cap_pin_i[c]),
         .cfg_i     (cap_cfg_t'(cctl_q[3*c +: 3])),
         .count_i   (tc_q),
         .cap_o     (cap_w[c]),
         .irq_set_o (cap_set_w[c]),
         .rise_o    (rise_w[c]),
         .fall_o    (fall_w[c])
      );
   end

   // counter-mode source selection
   logic src_rise, src_fall, cnt_evt;
   always_comb begin
      src_rise = 1'b0;
      src_fall = 1'b0;
      for (int i = 0; i < NUM_CAP; i++) begin
         if (ctrl_q[CB_SRC_LO +: 2] == 2'(i)) begin
            src_rise = rise_w[i];
            src_fall = fall_w[i];
         end
      end
   end
   assign cnt_evt = (ctrl_q[CB_EDGE_LO] && src_rise) || (ctrl_q[CB_EDGE_LO+1] && src_fall);

   logic tick;
   assign tick = en && !hold && (cmode ? cnt_evt : psc_wrap);

   // ---------------- match channels ----------------
   logic [NUM_MATCH-1:0] rst_req_w, stop_req_w, m_set_w;

   for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
      tmr_match_ch #(.W(CNT_W)) u_match (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .tick_i     (tick),
         .count_i    (tc_q),
         .match_i    (mr_q[m]),
         .cfg_i      (match_cfg_t'(mctl_q[3*m +: 3])),
         .act_i      (pin_act_e'(pinctl_q[2*m +: 2])),
         .rst_req_o  (rst_req_w[m]),
         .stop_req_o (stop_req_w[m]),
         .irq_set_o  (m_set_w[m]),
         .pin_o      (match_pin_o[m])
      );
   end

   logic any_rst, any_stop;
   assign any_rst  = |rst_req_w;
   assign any_stop = |stop_req_w;

   // ---------------- counter ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        tc_q <= '0;
      else if (hold)      tc_q <= '0;
      else if (tick) begin
         if (any_rst)        tc_q <= '0;
         else if (!any_stop) tc_q <= tc_q + 1'b1;
      end
   end

   // ---------------- configuration writes ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q   <= '0;
         pre_q    <= '0;
         mctl_q   <= '0;
         pinctl_q <= '0;
         cctl_q   <= '0;
         for (int i = 0; i < NUM_MATCH; i++) mr_q[i] <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata_i[7:0] & 8'hF7;
         if (any_stop) ctrl_q[CB_EN] <= 1'b0;
         if (bus_wr_i && bus_addr_i == A_PRE)    pre_q    <= bus_wdata_i;
         if (bus_wr_i && bus_addr_i == A_MCTL)   mctl_q   <= bus_wdata_i[MCT_W-1:0];
         if (bus_wr_i && bus_addr_i == A_PINCTL) pinctl_q <= bus_wdata_i[PIN_W-1:0];
         if (bus_wr_i && bus_addr_i == A_CCTL)   cctl_q   <= bus_wdata_i[CCT_W-1:0];
         for (int i = 0; i < NUM_MATCH; i++) begin
            if (bus_wr_i && bus_addr_i == A_MR0 + ADDR_W'(i)) mr_q[i] <= bus_wdata_i;
         end
      end
   end

   // ---------------- interrupt flags ----------------
   logic [NF-1:0] flag_clr;
   assign flag_clr = wr_flags ? bus_wdata_i[NF-1:0] : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= (flags_q & ~flag_clr) | {cap_set_w, m_set_w};
   end

   assign irq_o = |flags_q;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         A_CTRL:   bus_rdata_o[7:0]       = ctrl_q;
         A_PRE:    bus_rdata_o            = pre_q;
         A_CNT:    bus_rdata_o            = tc_q;
         A_PCNT:   bus_rdata_o            = pc_w;
         A_MCTL:   bus_rdata_o[MCT_W-1:0] = mctl_q;
         A_PINCTL: bus_rdata_o[PIN_W-1:0] = pinctl_q;
         A_CCTL:   bus_rdata_o[CCT_W-1:0] = cctl_q;
         A_FLAGS:  bus_rdata_o[NF-1:0]    = flags_q;
         default:  ;
      endcase
      for (int i = 0; i < NUM_MATCH; i++) begin
         if (bus_addr_i == A_MR0 + ADDR_W'(i)) bus_rdata_o = mr_q[i];
      end
      for (int i = 0; i < NUM_CAP; i++) begin
         if (bus_addr_i == A_CAP0 + ADDR_W'(i)) bus_rdata_o = cap_w[i];
      end
   end

   // ---------------- assertions ----------------
   p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick && !any_rst && !any_stop) |=> (tc_q == $past(tc_q) + 1'b1));

   p_freeze_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick && !hold) |=> $stable(tc_q));

   p_hold_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold |=> (tc_q == '0));

   p_reset_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_rst |=> (tc_q == '0));

   p_stop_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_stop |=> !ctrl_q[CB_EN]);

   p_stop_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_stop && !any_rst && !hold) |=> $stable(tc_q));

   p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   p_cmode_bypass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmode && !hold) |=> $stable(pc_w));

endmodule

// File: tb/test_tmr_match_capture.sv
module test_tmr_match_capture;
   import tmr_pkg::*;

   localparam int W  = 32;
   localparam int NM = 4;
   localparam int NC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    addr = '0;
   logic          wr_en = 1'b0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic [NC-1:0] cap_pins = '0;
   logic [NM-1:0] pins;
   logic          irq;

   always #4 clk = ~clk;

   tmr_match_capture #(.CNT_W(W), .NUM_MATCH(NM), .NUM_CAP(NC), .SYNC_STAGES(2)) i_tmr_match_capture (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr_en),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .cap_pin_i   (cap_pins),
      .match_pin_o (pins),
      .irq_o       (irq)
   );

   typedef struct {
      int          kind;   // 0 register, 1 match pins, 2 irq
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t exp_q[$];
   event  sample_ev;
   int    n_vec = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;

   // ---------------- driver tasks ----------------
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_item(input int kind, input logic [4:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      addr    = a;
      it.kind = kind;
      it.exp  = e;
      it.tag  = tag;
      exp_q.push_back(it);
      -> sample_ev;
   endtask

   task automatic reg_is(input logic [4:0] a, input logic [31:0] e, input string tag);
      expect_item(0, a, e, tag);
   endtask

   task automatic pins_are(input logic [31:0] e, input string tag);
      expect_item(1, 5'd0, e, tag);
   endtask

   task automatic irq_is(input logic [31:0] e, input string tag);
      expect_item(2, 5'd0, e, tag);
   endtask

   task automatic set_cap(input int ch, input logic v);
      @(negedge clk);
      cap_pins[ch] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic zero_counter();
      wr(A_CTRL, 32'h2);
      wr(A_CTRL, 32'h0);
   endtask

   // ---------------- monitor ----------------
   initial begin : monitor
      forever begin : one
         item_t       it;
         logic [31:0] act;
         @(sample_ev);
         #1;
         it = exp_q.pop_front();
         case (it.kind)
            0:       act = rdata;
            1:       act = {28'b0, pins};
            default: act = {31'b0, irq};
         endcase
         n_vec++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R1 watchdog actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin : stimulus
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_is(A_CTRL,  32'h0, "R1 control after reset");
      reg_is(A_CNT,   32'h0, "R1 counter after reset");
      reg_is(A_FLAGS, 32'h0, "R1 flags after reset");
      reg_is(A_CAP0,  32'h0, "R1 capture0 after reset");
      pins_are(32'h0, "R1 match pins after reset");
      irq_is(32'h0, "R1 irq after reset");

      // R2 prescaler: limit 3, 18 enabled edges -> count 4, prescaler 2
      wr(A_PRE, 32'd3);
      reg_is(A_PRE, 32'd3, "R10 prescale readback");
      wr(A_CTRL, 32'h1);
      repeat (16) @(negedge clk);
      wr(A_CTRL, 32'h0);
      reg_is(A_CNT,  32'd4, "R2 count after 18 cycles at limit 3");
      reg_is(A_PCNT, 32'd2, "R2 prescaler phase");
      wr(A_CTRL, 32'h2);
      reg_is(A_CNT,  32'd0, "R2 hold clears counter");
      reg_is(A_PCNT, 32'd0, "R2 hold clears prescaler");
      wr(A_CTRL, 32'h0);

      // R3/R5/R6: match0 at 4 with reset+irq, toggle pin; 7 steps -> count 2
      wr(A_PRE, 32'd0);
      wr(A_MR0, 32'd4);
      wr(A_MCTL, 32'h3);
      wr(A_PINCTL, 32'h3);
      reg_is(A_MR0,    32'd4, "R10 compare0 readback");
      reg_is(A_MCTL,   32'h3, "R10 match control readback");
      reg_is(A_PINCTL, 32'h3, "R10 pin control readback");
      wr(A_CTRL, 32'h1);
      repeat (5) @(negedge clk);
      wr(A_CTRL, 32'h0);
      reg_is(A_CNT, 32'd2, "R3 count wraps through zero after value 4");
      pins_are(32'h1, "R5 toggle after one hit");
      repeat (5) @(negedge clk);
      reg_is(A_FLAGS, 32'h1, "R6 match flag sticky");
      irq_is(32'h1, "R6 irq with flag set");
      wr(A_FLAGS, 32'h1);
      reg_is(A_FLAGS, 32'h0, "R6 write one clears flag");
      irq_is(32'h0, "R6 irq drops after clear");
      zero_counter();

      // R4/R5: match0 at 2 drives low, match1 at 3 stops and drives high
      wr(A_MR0, 32'd2);
      wr(A_MR0 + 5'd1, 32'd3);
      wr(A_MCTL, 32'h20);
      wr(A_PINCTL, 32'h9);
      wr(A_CTRL, 32'h1);
      repeat (20) @(negedge clk);
      reg_is(A_CNT, 32'd3, "R4 stop freezes at matched value");
      reg_is(A_CTRL, 32'h0, "R4 stop clears enable");
      pins_are(32'h2, "R5 low on ch0 and high on ch1");
      reg_is(A_FLAGS, 32'h0, "R6 no flag without irq action");

      // R4 reset+stop together; ch1 toggles 1 -> 0
      zero_counter();
      wr(A_MCTL, 32'h30);
      wr(A_PINCTL, 32'hC);
      wr(A_CTRL, 32'h1);
      repeat (20) @(negedge clk);
      reg_is(A_CNT, 32'd0, "R4 reset plus stop gives zero");
      reg_is(A_CTRL, 32'h0, "R4 reset plus stop clears enable");
      pins_are(32'h0, "R5 toggle back low");

      // R7/R8 capture: park counter at 5
      zero_counter();
      wr(A_PINCTL, 32'h0);
      wr(A_MR0 + 5'd1, 32'd5);
      wr(A_MCTL, 32'h20);
      wr(A_CTRL, 32'h1);
      repeat (20) @(negedge clk);
      reg_is(A_CNT, 32'd5, "R4 parked at 5");
      wr(A_CCTL, 32'hD5);
      reg_is(A_CCTL, 32'hD5, "R10 capture control readback");
      set_cap(0, 1'b1);
      reg_is(A_CAP0, 32'd5, "R7 rising capture on ch0");
      reg_is(A_FLAGS, 32'h10, "R8 capture0 flag at bit 4");
      irq_is(32'h1, "R8 irq from capture flag");
      set_cap(1, 1'b1);
      reg_is(A_CAP0 + 5'd1, 32'd0, "R7 rise ignored on fall-only ch1");
      wr(A_MR0 + 5'd1, 32'd7);
      wr(A_CTRL, 32'h1);
      repeat (20) @(negedge clk);
      reg_is(A_CNT, 32'd7, "R4 parked at 7");
      set_cap(1, 1'b0);
      reg_is(A_CAP0 + 5'd1, 32'd7, "R7 falling capture on ch1");
      set_cap(0, 1'b0);
      reg_is(A_CAP0, 32'd5, "R7 fall ignored on rise-only ch0");
      set_cap(2, 1'b1);
      reg_is(A_CAP0 + 5'd2, 32'd7, "R7 both-edge ch2 rising");
      wr(A_MR0 + 5'd1, 32'd9);
      wr(A_CTRL, 32'h1);
      repeat (20) @(negedge clk);
      set_cap(2, 1'b0);
      reg_is(A_CAP0 + 5'd2, 32'd9, "R7 both-edge ch2 falling");
      reg_is(A_FLAGS, 32'h10, "R8 no flag from irq-disabled channels");
      wr(A_FLAGS, 32'h10);
      reg_is(A_FLAGS, 32'h0, "R8 capture flag cleared");
      irq_is(32'h0, "R8 irq low after clear");

      // R9 counter mode on pin 2, rising edges, prescale limit 3 ignored
      zero_counter();
      wr(A_MCTL, 32'h0);
      wr(A_PRE, 32'd3);
      wr(A_CTRL, 32'h65);
      for (int k = 0; k < 3; k++) begin
         set_cap(2, 1'b1);
         set_cap(2, 1'b0);
      end
      reg_is(A_CNT, 32'd3, "R9 three rising edges counted");
      wr(A_CTRL, 32'hE5);
      for (int k = 0; k < 2; k++) begin
         set_cap(2, 1'b1);
         set_cap(2, 1'b0);
      end
      reg_is(A_CNT, 32'd7, "R9 both edges counted");
      set_cap(0, 1'b1);
      set_cap(0, 1'b0);
      reg_is(A_CNT, 32'd7, "R9 edges on unselected pin ignored");

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule